// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block produces the single interrupt line for a pair of transmit and receive FIFOs of equal depth (32 entries by default). It watches the FIFO fill levels and the push and pop strobes that reach them. From these it derives two kinds of interrupt source. Level sources follow the current fill level against a programmable threshold: the transmit side is running low, or the receive side has filled past its mark. Error sources are sticky and catch a push into a full FIFO or a pop from an empty one. The FIFO storage and the serial engine sit outside the block.

Software programs two thresholds and an enable mask through a small write port. It removes sticky errors by writing ones to a clear register. It can read back raw status, masked status and a FIFO status word through a combinational read port. The interrupt line is high whenever any enabled source is active.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset, both thresholds, the mask and all sticky error bits are zero, and the interrupt output is low.
- R2: Raw bit 0 (transmit low) is 1 exactly while the transmit level is less than or equal to the transmit threshold, so a threshold of 0 flags only a fully empty transmit FIFO.
- R3: Raw bit 4 (receive high) is 1 exactly while the receive level is strictly greater than the receive threshold, so a threshold of N-1 flags N or more entries.
- R4: A transmit push while the transmit level equals the depth sets raw bit 1, which then stays set until cleared. A push at any lower level sets nothing.
- R5: A receive pop at receive level 0 sets raw bit 2. A receive push at receive level equal to the depth sets raw bit 3. Both bits are sticky.
- R6: Writing the clear register (address 3) removes sticky bits. Data bit 3 clears raw bit 1, data bit 2 clears raw bit 3, data bit 1 clears raw bit 2, and data bit 0 clears all three. Other sticky bits are left as they are.
- R7: Clear writes have no effect on the level bits, raw bits 0 and 4.
- R8: When a sticky error event and its clear fall in the same cycle, the bit ends up set.
- R9: Masked status (address 5) equals raw status (address 4) ANDed with the mask (address 2, bits 4:0). The interrupt output is high exactly when any masked bit is 1.
- R10: The FIFO status word (address 6) holds, in its low bits, bit 4 receive full (level = depth), bit 3 receive empty (level 0), bit 2 transmit empty, bit 1 transmit full and bit 0 the busy input.
- R11: The transmit threshold is at address 0 and the receive threshold at address 1, each in data bits 4:0. Writes to addresses 3 to 7 change no threshold or mask value, and the clear register reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 6 | Transmit FIFO fill level, 0 to depth |
| rx_level | input | 6 | Receive FIFO fill level, 0 to depth |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| rx_push | input | 1 | Write strobe into the receive FIFO |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| engine_busy | input | 1 | Serial engine activity, reported in the status word |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq_out | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. An error event always leaves its sticky bit set on the next cycle, even against a clear. A clear without an event drops the bit, and a sticky bit with no clear holds. Configuration is stable across cycles without a write. An empty transmit FIFO always shows the transmit-low source, an empty receive FIFO never shows the receive-high source, and a zero mask keeps the interrupt low. The bench scenarios are needed for the rest. They cover the exact threshold boundaries on both sides, the mapping of each clear bit to its target, the fact that a push just below full sets nothing, and the layout of the status and masked words.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int DEF_DEPTH  = 32;
    localparam int DEF_DATA_W = 8;
    localparam int ADDR_W     = 3;
    localparam int N_SRC      = 5;
    localparam int N_ERR      = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TX_THR  = 3'd0,
        A_RX_THR  = 3'd1,
        A_MASK    = 3'd2,
        A_CLEAR   = 3'd3,
        A_RAW     = 3'd4,
        A_MASKED  = 3'd5,
        A_FSTAT   = 3'd6,
        A_UNUSED  = 3'd7
    } reg_addr_e;

    // source bit positions shared by raw, mask and masked words
    localparam int S_TX_LOW = 0;
    localparam int S_TX_OVF = 1;
    localparam int S_RX_UNF = 2;
    localparam int S_RX_OVF = 3;
    localparam int S_RX_HI  = 4;

    // sticky error vector order
    localparam int E_TX_OVF = 0;
    localparam int E_RX_UNF = 1;
    localparam int E_RX_OVF = 2;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import fifo_irq_pkg::*;
#(
    parameter int THR_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [THR_W-1:0]  tx_thr_q,
    output logic [THR_W-1:0]  rx_thr_q,
    output logic [N_SRC-1:0]  mask_q
);

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic [N_SRC-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                A_TX_THR: cfg_d.tx_thr = wdata[THR_W-1:0];
                A_RX_THR: cfg_d.rx_thr = wdata[THR_W-1:0];
                A_MASK:   cfg_d.mask   = wdata[N_SRC-1:0];
                default:  cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign tx_thr_q = cfg_q.tx_thr;
    assign rx_thr_q = cfg_q.rx_thr;
    assign mask_q   = cfg_q.mask;

    // R11: without a write to a config address, configuration holds
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (addr == A_TX_THR || addr == A_RX_THR || addr == A_MASK))
        |=> $stable({tx_thr_q, rx_thr_q, mask_q}));

endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6,
    parameter int THR_W = 5
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic             tx_push,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             busy,
    output logic             tx_low,
    output logic             rx_high,
    output logic [N_ERR-1:0] err_set,
    output logic [4:0]       fstat
);

    localparam logic [LVL_W-1:0] FULL_LVL  = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] EMPTY_LVL = '0;
    localparam int               PAD_W     = LVL_W - THR_W;

    logic tx_full, tx_empty, rx_full, rx_empty;

    always_comb begin
        tx_full  = (tx_level == FULL_LVL);
        tx_empty = (tx_level == EMPTY_LVL);
        rx_full  = (rx_level == FULL_LVL);
        rx_empty = (rx_level == EMPTY_LVL);

        tx_low  = (tx_level <= {{PAD_W{1'b0}}, tx_thr});
        rx_high = (rx_level >  {{PAD_W{1'b0}}, rx_thr});

        err_set           = '0;
        err_set[E_TX_OVF] = tx_push && tx_full;
        err_set[E_RX_UNF] = rx_pop  && rx_empty;
        err_set[E_RX_OVF] = rx_push && rx_full;

        fstat = {rx_full, rx_empty, tx_empty, tx_full, busy};
    end

endmodule

// File: rtl/irq_err_sticky.sv
module irq_err_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] err_q
);

    typedef struct packed {
        logic [N-1:0] err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.err = (st_q.err & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_q = st_q.err;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R8: an event always leaves its bit set, even against a clear
        a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> err_q[i]);
        // R6: a clear without a coincident event drops the bit
        a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !err_q[i]);
        // R4: a set bit with no clear holds
        a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[i] && !clr_i[i]) |=> err_q[i]);
    end

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int DATA_W = DEF_DATA_W,
    parameter int LVL_W  = $clog2(DEPTH) + 1,
    parameter int THR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_push,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              engine_busy,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);

    logic [THR_W-1:0] tx_thr, rx_thr;
    logic [N_SRC-1:0] mask;
    logic             tx_low, rx_high;
    logic [N_ERR-1:0] err_set, err_clr, err_q;
    logic [4:0]       fstat;
    logic [N_SRC-1:0] raw, masked;
    logic             clr_wr;

    irq_cfg_regs #(.THR_W(THR_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .tx_thr_q(tx_thr), .rx_thr_q(rx_thr), .mask_q(mask)
    );

    irq_level_eval #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) u_lvl (
        .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .busy(engine_busy),
        .tx_low(tx_low), .rx_high(rx_high), .err_set(err_set), .fstat(fstat)
    );

    always_comb begin
        clr_wr            = reg_we && (reg_addr == A_CLEAR);
        err_clr           = '0;
        err_clr[E_TX_OVF] = clr_wr && (reg_wdata[3] || reg_wdata[0]);
        err_clr[E_RX_OVF] = clr_wr && (reg_wdata[2] || reg_wdata[0]);
        err_clr[E_RX_UNF] = clr_wr && (reg_wdata[1] || reg_wdata[0]);
    end

    irq_err_sticky #(.N(N_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .err_q(err_q)
    );

    always_comb begin
        raw           = '0;
        raw[S_TX_LOW] = tx_low;
        raw[S_TX_OVF] = err_q[E_TX_OVF];
        raw[S_RX_UNF] = err_q[E_RX_UNF];
        raw[S_RX_OVF] = err_q[E_RX_OVF];
        raw[S_RX_HI]  = rx_high;
        masked        = raw & mask;
        irq_out       = |masked;

        reg_rdata = '0;
        case (reg_addr)
            A_TX_THR: reg_rdata[THR_W-1:0] = tx_thr;
            A_RX_THR: reg_rdata[THR_W-1:0] = rx_thr;
            A_MASK:   reg_rdata[N_SRC-1:0] = mask;
            A_RAW:    reg_rdata[N_SRC-1:0] = raw;
            A_MASKED: reg_rdata[N_SRC-1:0] = masked;
            A_FSTAT:  reg_rdata[4:0]       = fstat;
            default:  reg_rdata            = '0;
        endcase
    end

    // R9: a zero mask never lets the interrupt through
    a_r9_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_out);
    // R2: an empty transmit FIFO is always at or below any threshold
    a_r2_tx_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> tx_low);
    // R3: an empty receive FIFO never exceeds a threshold
    a_r3_rx_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !rx_high);
    // R1: the cycle after reset release no sticky error is pending
    a_r1_reset_clean: assert property (@(posedge clk)
        $rose(rst_n) |-> (err_q == '0));

endmodule

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] tx_level = '0, rx_level = '0;
    logic       tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, engine_busy = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fifo_irq_ctrl i_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
        .engine_busy(engine_busy), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // {tx_level, rx_level, tx_thr, rx_thr, exp_tx_low, exp_rx_high}
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        {6'd0,  6'd0,  5'd0,  5'd0,  1'b1, 1'b0},
        {6'd1,  6'd1,  5'd0,  5'd0,  1'b0, 1'b1},
        {6'd16, 6'd16, 5'd16, 5'd16, 1'b1, 1'b0},
        {6'd17, 6'd17, 5'd16, 5'd16, 1'b0, 1'b1},
        {6'd32, 6'd32, 5'd31, 5'd31, 1'b0, 1'b1},
        {6'd31, 6'd31, 5'd31, 5'd31, 1'b1, 1'b0},
        {6'd5,  6'd3,  5'd10, 5'd10, 1'b1, 1'b0},
        {6'd20, 6'd8,  5'd4,  5'd4,  1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic pulse(input bit tp, input bit rp, input bit rpop);
        @(negedge clk);
        tx_push = tp; rx_push = rp; rx_pop = rpop;
        @(negedge clk);
        tx_push = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, v); chk("R1 tx_thr", v, 8'h00);
        rd(3'd1, v); chk("R1 rx_thr", v, 8'h00);
        rd(3'd2, v); chk("R1 mask", v, 8'h00);
        rd(3'd4, v); chk("R1 raw", v, 8'h01);
        chk("R1 irq", {7'd0, irq_out}, 8'h00);

        // R2 R3: table of level/threshold vectors
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, {3'd0, VEC[i][11:7]});
            wr(3'd1, {3'd0, VEC[i][6:2]});
            @(negedge clk);
            tx_level = VEC[i][23:18];
            rx_level = VEC[i][17:12];
            rd(3'd4, v);
            chk("R2 tx_low", {7'd0, v[0]}, {7'd0, VEC[i][1]});
            chk("R3 rx_high", {7'd0, v[4]}, {7'd0, VEC[i][0]});
        end

        // R11: map and ignored writes
        wr(3'd0, 8'h05); wr(3'd1, 8'h09); wr(3'd2, 8'h00);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd0, v); chk("R11 tx_thr kept", v, 8'h05);
        rd(3'd1, v); chk("R11 rx_thr kept", v, 8'h09);
        rd(3'd2, v); chk("R11 mask kept", v, 8'h00);
        rd(3'd3, v); chk("R11 clear reads 0", v, 8'h00);

        // R4: push below full sets nothing, push at full sets bit 1
        wr(3'd0, 8'h00); wr(3'd1, 8'h1F);
        tx_level = 6'd31; rx_level = 6'd10;
        pulse(1, 0, 0);
        rd(3'd4, v); chk("R4 no ovf below full", v, 8'h00);
        tx_level = 6'd32;
        pulse(1, 0, 0);
        tx_level = 6'd10;
        rd(3'd4, v); chk("R4 tx ovf sticky", v, 8'h02);

        // R6: wrong clear bit keeps it, correct bit clears it
        wr(3'd3, 8'h04);
        rd(3'd4, v); chk("R6 bit2 leaves tx ovf", v, 8'h02);
        wr(3'd3, 8'h08);
        rd(3'd4, v); chk("R6 bit3 clears tx ovf", v, 8'h00);

        // R5: rx underflow and overflow
        rx_level = 6'd0;
        pulse(0, 0, 1);
        rd(3'd4, v); chk("R5 rx unf", v, 8'h04);
        rx_level = 6'd32;
        pulse(0, 1, 0);
        rx_level = 6'd10;
        rd(3'd4, v); chk("R5 rx ovf", v, 8'h0C);
        wr(3'd3, 8'h02);
        rd(3'd4, v); chk("R6 bit1 clears unf only", v, 8'h08);
        wr(3'd3, 8'h04);
        rd(3'd4, v); chk("R6 bit2 clears rx ovf", v, 8'h00);
        tx_level = 6'd32;
        pulse(1, 0, 0);
        rx_level = 6'd0;
        pulse(0, 0, 1);
        tx_level = 6'd10; rx_level = 6'd10;
        wr(3'd3, 8'h01);
        rd(3'd4, v); chk("R6 bit0 clears all", v, 8'h00);

        // R7: clear has no effect on level bits
        wr(3'd1, 8'h00);
        tx_level = 6'd0; rx_level = 6'd5;
        wr(3'd3, 8'h0F);
        rd(3'd4, v); chk("R7 level bits survive clear", v, 8'h11);

        // R8: set and clear in the same cycle
        tx_level = 6'd32;
        @(negedge clk);
        tx_push = 1'b1; reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h08;
        @(negedge clk);
        tx_push = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        rd(3'd4, v); chk("R8 set wins", {7'd0, v[1]}, 8'h01);

        // R9: mask and interrupt (raw now 0x12: tx ovf + rx high)
        rd(3'd4, v); chk("R9 raw", v, 8'h12);
        chk("R9 irq masked off", {7'd0, irq_out}, 8'h00);
        wr(3'd2, 8'h01);
        rd(3'd5, v); chk("R9 masked none", v, 8'h00);
        chk("R9 irq low", {7'd0, irq_out}, 8'h00);
        wr(3'd2, 8'h12);
        rd(3'd5, v); chk("R9 masked both", v, 8'h12);
        chk("R9 irq high", {7'd0, irq_out}, 8'h01);
        wr(3'd3, 8'h08);
        wr(3'd2, 8'h02);
        rd(3'd5, v); chk("R9 masked after clear", v, 8'h00);
        chk("R9 irq dropped", {7'd0, irq_out}, 8'h00);

        // R10: FIFO status word
        tx_level = 6'd32; rx_level = 6'd0; engine_busy = 1'b1;
        rd(3'd6, v); chk("R10 status a", v, 8'h0B);
        tx_level = 6'd0; rx_level = 6'd32; engine_busy = 1'b0;
        rd(3'd6, v); chk("R10 status b", v, 8'h14);

        done = 1'b1;
        summary();
    end

endmodule